// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout

This block is a host-serviced watchdog for a peripheral device. The host writes a small configuration word, which holds an enable bit, a two-bit timeout select and a two-bit action code. It keeps the watchdog alive by pulsing a service (trigger) strobe. After reset the watchdog is enabled but idle. It starts counting only when the first service pulse arrives. Each later pulse reloads the count from the selected period.

When the count runs out, the block raises a sticky timeout flag. The flag feeds two summary bits: one summary for voltage, temperature and watchdog faults, and one global error summary. Depending on the action code, the timeout can also pull an active-low watchdog pin low, provided that pin is routed to the watchdog. The host clears the flag by writing a one to its clear strobe.

Time is measured in millisecond ticks from a prescaler. The prescaler divides the clock by the parameter `TICKS_PER_MS`, so a bench can shrink the periods.

Top module: `wdt_sel_timeout`

## Requirements
- R1: After reset, the watchdog is enabled, the select code is 00 and the action code is 00. The timeout flag and both summary bits are 0 and `wdt_pin_n` is 1.
- R2: Select code 00, 01, 10 and 11 gives a period of 60, 600, 3000 and 6000 ms ticks. With `P` the period, `wdt_flag` rises exactly `P*TICKS_PER_MS` clock edges after the edge that samples the accepted service pulse.
- R3: While enabled, the watchdog never times out until a service pulse has been accepted since enable was last set, however long it waits.
- R4: A service pulse accepted while counting reloads the full selected period, so the timeout is measured from the latest pulse.
- R5: Writing the enable bit to 0 stops the watchdog at once. A count in progress never expires, and service pulses are ignored while the watchdog is disabled.
- R6: `irq_vtwd` is the OR of the timeout flag and `ext_vt_flag`. `irq_global` is the OR of `irq_vtwd` and `ext_err_flag`.
- R7: The timeout flag stays set until a pulse on `flag_clr`. After a timeout the counter stays idle until a new service pulse arrives.
- R8: Writing a new select code while counting leaves the current count alone. The new period applies from the next service pulse.
- R9: `wdt_pin_n` is 0 exactly when the flag is set, `pin_route_wdt` is 1 and the action code is not 01. Action code 01 only flags the timeout. Codes 00, 10 and 11 flag it and drive the pin. Clearing the flag releases the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_en_d | input | 1 | Enable value written by `cfg_we` |
| cfg_sel_d | input | 2 | Timeout select written by `cfg_we` |
| cfg_act_d | input | 2 | Action code written by `cfg_we` |
| svc_we | input | 1 | Service (trigger) write strobe |
| flag_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| pin_route_wdt | input | 1 | 1 when the output pin is assigned to the watchdog |
| ext_vt_flag | input | 1 | Voltage or temperature fault from elsewhere |
| ext_err_flag | input | 1 | Other error source for the global summary |
| wdt_flag | output | 1 | Sticky watchdog timeout flag |
| irq_vtwd | output | 1 | Voltage, temperature or watchdog summary bit |
| irq_global | output | 1 | Global error summary bit |
| wdt_pin_n | output | 1 | Active-low watchdog pin |

## Verification
The hardest case to reach from the ports is the exact expiry edge of the long periods. A close second is a count whose select code was rewritten mid-run. Both need thousands of ticks to pass with the pin and flags showing nothing in between. The bench therefore sets the prescaler to two clocks per tick. It then checks the flag on the edge before the expected expiry and on the expiry edge itself, after a select rewrite, a disable in mid-count, and several random early service pulses that must each push the expiry out.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned PERIOD_MAX_MS = 6000;
   localparam int unsigned MS_W          = $clog2(PERIOD_MAX_MS + 1);

   typedef enum logic [1:0] {
      ACT_FLAG_PIN  = 2'b00,
      ACT_FLAG_ONLY = 2'b01,
      ACT_RSVD_A    = 2'b10,
      ACT_RSVD_B    = 2'b11
   } wdt_act_e;

   function automatic logic [MS_W-1:0] period_ms(input logic [1:0] sel);
      case (sel)
         2'b00:   period_ms = MS_W'(60);
         2'b01:   period_ms = MS_W'(600);
         2'b10:   period_ms = MS_W'(3000);
         default: period_ms = MS_W'(PERIOD_MAX_MS);
      endcase
   endfunction
endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
   parameter int unsigned DIV = 40000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   initial begin
      if (DIV < 1) $error("wdt_tick: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pcnt <= '0;
            else if (restart)           pcnt <= '0;
            else if (pcnt == PW'(DIV-1)) pcnt <= '0;
            else                        pcnt <= pcnt + 1'b1;
         end
         assign tick = (pcnt == PW'(DIV-1));
      end
   endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            load,
   input  logic [1:0]      sel,
   input  logic            tick,
   output logic            running,
   output logic            expire
);
   logic [MS_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (!en) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (load) begin
         running <= 1'b1;
         cnt     <= period_ms(sel);
      end else if (running && tick) begin
         cnt <= cnt - 1'b1;
         if (cnt == MS_W'(1)) running <= 1'b0;
      end
   end

   assign expire = running && tick && !load && en && (cnt == MS_W'(1));

   p_disable_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !running);
   p_count_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt != '0) && (cnt <= MS_W'(PERIOD_MAX_MS)));
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic       clr,
   input  logic [1:0] act,
   input  logic       route,
   input  logic       ext_vt,
   input  logic       ext_err,
   output logic       flag,
   output logic       vtwd,
   output logic       global_err,
   output logic       pin_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (expire) flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
   end

   assign vtwd       = flag | ext_vt;
   assign global_err = vtwd | ext_err;
   assign pin_n      = !(flag && route && (wdt_act_e'(act) != ACT_FLAG_ONLY));

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag);
   p_flag_from_expiry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(expire));
endmodule

// File: rtl/wdt_sel_timeout.sv
module wdt_sel_timeout
   import wdt_pkg::*;
#(
   parameter int unsigned TICKS_PER_MS = 40000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic       cfg_en_d,
   input  logic [1:0] cfg_sel_d,
   input  logic [1:0] cfg_act_d,
   input  logic       svc_we,
   input  logic       flag_clr,
   input  logic       pin_route_wdt,
   input  logic       ext_vt_flag,
   input  logic       ext_err_flag,
   output logic       wdt_flag,
   output logic       irq_vtwd,
   output logic       irq_global,
   output logic       wdt_pin_n
);
   initial begin
      if (TICKS_PER_MS < 1) $error("wdt_sel_timeout: TICKS_PER_MS must be at least 1");
   end

   logic       en_q;
   logic [1:0] sel_q;
   logic [1:0] act_q;
   logic       load, tick, running, expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b1;
         sel_q <= 2'b00;
         act_q <= ACT_FLAG_PIN;
      end else if (cfg_we) begin
         en_q  <= cfg_en_d;
         sel_q <= cfg_sel_d;
         act_q <= cfg_act_d;
      end
   end

   assign load = svc_we && en_q;

   wdt_tick #(.DIV(TICKS_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(load), .tick(tick));

   wdt_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_q), .load(load), .sel(sel_q),
      .tick(tick), .running(running), .expire(expire));

   wdt_irq u_irq (
      .clk(clk), .rst_n(rst_n), .expire(expire), .clr(flag_clr),
      .act(act_q), .route(pin_route_wdt), .ext_vt(ext_vt_flag),
      .ext_err(ext_err_flag), .flag(wdt_flag), .vtwd(irq_vtwd),
      .global_err(irq_global), .pin_n(wdt_pin_n));

   p_pin_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wdt_pin_n |-> wdt_flag && pin_route_wdt);
   p_summary_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_flag |-> irq_vtwd && irq_global);
   p_no_expiry_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> !$rose(wdt_flag));
endmodule

// File: tb/tb_wdt_sel_timeout.sv
module tb_wdt_sel_timeout;
   localparam int T = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0, cfg_en_d = 0, svc_we = 0, flag_clr = 0;
   logic [1:0] cfg_sel_d = 0, cfg_act_d = 0;
   logic pin_route_wdt = 1, ext_vt_flag = 0, ext_err_flag = 0;
   logic wdt_flag, irq_vtwd, irq_global, wdt_pin_n;
   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   wdt_sel_timeout #(.TICKS_PER_MS(T)) dut (.*);

   function automatic int exp_period(input int sel);
      case (sel)
         0: return 60;
         1: return 600;
         2: return 3000;
         default: return 6000;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_svc();
      @(negedge clk) svc_we = 1;
      @(negedge clk) svc_we = 0;
   endtask

   task automatic pulse_clr();
      @(negedge clk) flag_clr = 1;
      @(negedge clk) flag_clr = 0;
   endtask

   task automatic write_cfg(input logic en, input logic [1:0] sel, input logic [1:0] act);
      @(negedge clk) begin cfg_we = 1; cfg_en_d = en; cfg_sel_d = sel; cfg_act_d = act; end
      @(negedge clk) cfg_we = 0;
   endtask

   // called right after pulse_svc; n edges counted from the sampling edge
   task automatic expect_expiry(input int n, input string req);
      repeat (n - 1) @(negedge clk);
      check(req, wdt_flag, 0);
      @(negedge clk);
      check(req, wdt_flag, 1);
   endtask

   task automatic wait_quiet(input int n, input string req);
      repeat (n) @(negedge clk);
      check(req, wdt_flag, 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual 0 expected 1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 flag", wdt_flag, 0);
      check("R1 vtwd", irq_vtwd, 0);
      check("R1 global", irq_global, 0);
      check("R1 pin", wdt_pin_n, 1);

      wait_quiet(70 * T, "R3 no trigger after reset");

      pulse_svc();
      expect_expiry(60 * T, "R1 R2 default 60 ms");
      check("R6 vtwd", irq_vtwd, 1);
      check("R6 global", irq_global, 1);
      check("R9 pin low", wdt_pin_n, 0);

      repeat (100) @(negedge clk);
      check("R7 sticky", wdt_flag, 1);
      pulse_clr();
      check("R7 cleared", wdt_flag, 0);
      check("R9 pin released", wdt_pin_n, 1);
      wait_quiet(70 * T, "R7 idle after timeout");

      for (int s = 0; s < 4; s++) begin
         write_cfg(1, 2'(s), 2'b00);
         pulse_svc();
         expect_expiry(exp_period(s) * T, $sformatf("R2 select %0d", s));
         pulse_clr();
      end

      write_cfg(1, 2'b00, 2'b00);
      pulse_svc();
      repeat (50 * T) @(negedge clk);
      pulse_svc();
      expect_expiry(60 * T, "R4 reload");
      pulse_clr();

      pulse_svc();
      repeat (5) @(negedge clk);
      write_cfg(1, 2'b01, 2'b00);
      expect_expiry(60 * T - 7, "R8 old period kept");
      pulse_clr();
      pulse_svc();
      expect_expiry(600 * T, "R8 new period on reload");
      pulse_clr();

      write_cfg(1, 2'b00, 2'b00);
      pulse_svc();
      repeat (20) @(negedge clk);
      write_cfg(0, 2'b00, 2'b00);
      wait_quiet(70 * T, "R5 disable stops count");
      pulse_svc();
      wait_quiet(70 * T, "R5 trigger ignored when off");
      write_cfg(1, 2'b00, 2'b00);
      wait_quiet(70 * T, "R3 re-enable waits for trigger");
      pulse_svc();
      expect_expiry(60 * T, "R5 runs after re-enable");
      pulse_clr();

      write_cfg(1, 2'b00, 2'b01);
      pulse_svc();
      expect_expiry(60 * T, "R9 flag-only action");
      check("R9 action 01 pin high", wdt_pin_n, 1);
      pulse_clr();
      write_cfg(1, 2'b00, 2'b10);
      pin_route_wdt = 0;
      pulse_svc();
      expect_expiry(60 * T, "R9 unrouted");
      check("R9 unrouted pin high", wdt_pin_n, 1);
      pin_route_wdt = 1;
      @(negedge clk);
      check("R9 action 10 pin low", wdt_pin_n, 0);
      pulse_clr();

      ext_vt_flag = 1;
      @(negedge clk);
      check("R6 ext vt vtwd", irq_vtwd, 1);
      check("R6 ext vt global", irq_global, 1);
      ext_vt_flag = 0; ext_err_flag = 1;
      @(negedge clk);
      check("R6 ext err vtwd", irq_vtwd, 0);
      check("R6 ext err global", irq_global, 1);
      check("R6 ext err flag", wdt_flag, 0);
      ext_err_flag = 0;

      for (int it = 0; it < 5; it++) begin
         int s = int'($urandom % 3);
         int p = exp_period(s) * T;
         int k = 1 + int'($urandom % 3);
         write_cfg(1, 2'(s), 2'(($urandom % 2) * 2));
         pulse_svc();
         for (int j = 0; j < k; j++) begin
            repeat (1 + int'($urandom % (p - 2))) @(negedge clk);
            pulse_svc();
         end
         expect_expiry(p, $sformatf("R4 random run %0d", it));
         pulse_clr();
      end

      finish_run();
   end
endmodule